// File: doc/BRIEF.md
# Three-Wire Synthesizer Programming Interface

This block takes the three-wire serial programming stream of a dual-channel frequency synthesizer and turns it into parallel settings. The serial clock, data and load-enable pins are brought into the system clock domain. Each synchronised rising edge of the serial clock shifts one data bit into a 23-bit word. When load-enable rises, the word is copied into one of four holding registers. The two bits shifted in last choose which register.

Two channels are served, a low band and a high band. Each has a reference-divider register and a main-counter register. The reference word carries the 14-bit reference ratio, the charge-pump current select and the two test bits. The main-counter word carries the 7-bit swallow count, the 11-bit programmable count, the prescaler select, the detector polarity and the monitor-select bit. The block also drives the shared lock/monitor output. It shows either the lock indication or one of four divided-frequency signals, as the most recently loaded words select.

Top module: `synth_prog_if`

## Requirements
- R1: After reset every latched field, and therefore every setting output, is zero.
- R2: Each synchronised rising edge of `serClk` while `serLoad` is low shifts `serData` in as the new bit 0 and moves older bits up, so the first bit sent lands in bit 22. Only the last 23 bits are kept.
- R3: A synchronised rising edge of `serLoad` copies the word into exactly one register group, chosen by {bit0,bit1}: 00 low-band reference, 10 high-band reference, 01 low-band counter, 11 high-band counter. All other groups keep their values.
- R4: In a reference word, bits 17:4 hold the reference ratio, with bit 4 as its least significant bit. Bit 18 is the charge-pump select: 1 selects high current and 0 selects low current. Bits 22:19 are ignored.
- R5: In a counter word, bit 3 is the prescaler select and bit 4 is the detector polarity. Bits 11:5 hold the swallow count and bits 22:12 hold the programmable count.
- R6: Rising edges of `serClk` while `serLoad` is high do not shift. A later load copies the word that was held before them.
- R7: The test pair `testSel` = {bit2,bit3} comes from the most recently loaded reference word of either band. The monitor select `monSelFreq` is bit 2 of the most recently loaded counter word of either band.
- R8: When `monSelFreq` is 0, `monOut` follows `lockIn`. When it is 1, `monOut` shows the signal that `testSel` chooses: 00 `frLo`, 10 `frHi`, 01 `fpLo`, 11 `fpHi`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serClk | input | 1 | Serial shift clock (asynchronous) |
| serData | input | 1 | Serial data, most significant bit first |
| serLoad | input | 1 | Load enable; its rising edge latches the word |
| lockIn | input | 1 | Lock indication to be shown on the monitor output |
| frLo | input | 1 | Low-band divided reference signal |
| frHi | input | 1 | High-band divided reference signal |
| fpLo | input | 1 | Low-band divided feedback signal |
| fpHi | input | 1 | High-band divided feedback signal |
| loRefDiv | output | 14 | Low-band reference ratio |
| loCpHigh | output | 1 | Low-band charge-pump high current |
| hiRefDiv | output | 14 | High-band reference ratio |
| hiCpHigh | output | 1 | High-band charge-pump high current |
| loSwallow | output | 7 | Low-band swallow count |
| loProgDiv | output | 11 | Low-band programmable count |
| loPreSel | output | 1 | Low-band prescaler select |
| loPolarity | output | 1 | Low-band detector polarity |
| hiSwallow | output | 7 | High-band swallow count |
| hiProgDiv | output | 11 | High-band programmable count |
| hiPreSel | output | 1 | High-band prescaler select |
| hiPolarity | output | 1 | High-band detector polarity |
| testSel | output | 2 | Test pair {T1,T2} from the last reference word |
| monSelFreq | output | 1 | Monitor select from the last counter word |
| monOut | output | 1 | Shared lock/monitor output |

## Verification
The assertions watch three things on every cycle: the cleared state during reset, that no register group moves without a load strobe, and that a load touches at most one group. They also check that a low-band reference load takes its ratio from the right bits of the shifted word. Other behaviour can only be shown by the scenarios, because it depends on a whole serial transfer: the order in which bits land, the ignored clocks while load is high, the loss of surplus leading bits, and which word last set the shared test pair and monitor select.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;
  localparam int WORD_W  = 23;
  localparam int REF_W   = 14;
  localparam int SWAL_W  = 7;
  localparam int PROG_W  = 11;

  // bit positions inside the shifted word (decoded by the latches)
  localparam int POS_CN1  = 0;
  localparam int POS_CN2  = 1;
  localparam int POS_T1   = 2;
  localparam int POS_T2   = 3;
  localparam int POS_REF  = 4;
  localparam int POS_CS   = POS_REF + REF_W;
  localparam int POS_LDS  = 2;
  localparam int POS_SW   = 3;
  localparam int POS_FC   = 4;
  localparam int POS_SWAL = 5;
  localparam int POS_PROG = POS_SWAL + SWAL_W;

  typedef struct packed {
    logic shiftEn;
    logic shiftBit;
    logic loadEn;
  } strobe_t;
endpackage

// File: rtl/synth_prog_ctrl.sv
module synth_prog_ctrl
  import synth_prog_pkg::*;
#(
  parameter int SYNC_DEPTH = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    serClk,
  input  logic    serData,
  input  logic    serLoad,
  output strobe_t strb
);
  localparam int LANES = 3;

  // stage 0..SYNC_DEPTH-1 synchronise, stage SYNC_DEPTH is the edge history
  logic [LANES-1:0] pipe [SYNC_DEPTH+1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe[0] <= '0;
    else       pipe[0] <= {serLoad, serData, serClk};
  end

  for (genvar s = 1; s <= SYNC_DEPTH; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pipe[s] <= '0;
      else       pipe[s] <= pipe[s-1];
    end
  end

  logic clkNow, clkOld, loadNow, loadOld, dataNow;
  assign clkNow  = pipe[SYNC_DEPTH-1][0];
  assign clkOld  = pipe[SYNC_DEPTH][0];
  assign dataNow = pipe[SYNC_DEPTH-1][1];
  assign loadNow = pipe[SYNC_DEPTH-1][2];
  assign loadOld = pipe[SYNC_DEPTH][2];

  always_comb begin
    strb.shiftEn  = clkNow && !clkOld && !loadNow && !loadOld;
    strb.shiftBit = dataNow;
    strb.loadEn   = loadNow && !loadOld;
  end
endmodule

// File: rtl/synth_prog_dp.sv
module synth_prog_dp
  import synth_prog_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              lockIn,
  input  logic              frLo,
  input  logic              frHi,
  input  logic              fpLo,
  input  logic              fpHi,
  output logic [WORD_W-1:0] shiftWord,
  output logic [REF_W-1:0]  refDiv  [2],
  output logic              cpHigh  [2],
  output logic [SWAL_W-1:0] swallow [2],
  output logic [PROG_W-1:0] progDiv [2],
  output logic              preSel  [2],
  output logic              polarity[2],
  output logic [1:0]        testSel,
  output logic              monSelFreq,
  output logic              monOut
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             shiftWord <= '0;
    else if (strb.shiftEn) shiftWord <= {shiftWord[WORD_W-2:0], strb.shiftBit};
  end

  logic isProg;
  assign isProg = shiftWord[POS_CN2];

  // band 0 = low (CN1 = 0), band 1 = high (CN1 = 1)
  for (genvar b = 0; b < 2; b++) begin : g_band
    logic hit;
    assign hit = strb.loadEn && (shiftWord[POS_CN1] == b[0]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        refDiv[b] <= '0;
        cpHigh[b] <= 1'b0;
      end else if (hit && !isProg) begin
        refDiv[b] <= shiftWord[POS_REF +: REF_W];
        cpHigh[b] <= shiftWord[POS_CS];
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        swallow[b]  <= '0;
        progDiv[b]  <= '0;
        preSel[b]   <= 1'b0;
        polarity[b] <= 1'b0;
      end else if (hit && isProg) begin
        swallow[b]  <= shiftWord[POS_SWAL +: SWAL_W];
        progDiv[b]  <= shiftWord[POS_PROG +: PROG_W];
        preSel[b]   <= shiftWord[POS_SW];
        polarity[b] <= shiftWord[POS_FC];
      end
    end
  end

  // shared mode bits: the last word of each kind wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      testSel    <= '0;
      monSelFreq <= 1'b0;
    end else if (strb.loadEn) begin
      if (!isProg) testSel    <= {shiftWord[POS_T1], shiftWord[POS_T2]};
      else         monSelFreq <= shiftWord[POS_LDS];
    end
  end

  always_comb begin
    if (!monSelFreq) monOut = lockIn;
    else begin
      unique case (testSel)
        2'b00:   monOut = frLo;
        2'b10:   monOut = frHi;
        2'b01:   monOut = fpLo;
        default: monOut = fpHi;
      endcase
    end
  end
endmodule

// File: rtl/synth_prog_if.sv
module synth_prog_if
  import synth_prog_pkg::*;
#(
  parameter int SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serClk,
  input  logic              serData,
  input  logic              serLoad,
  input  logic              lockIn,
  input  logic              frLo,
  input  logic              frHi,
  input  logic              fpLo,
  input  logic              fpHi,
  output logic [REF_W-1:0]  loRefDiv,
  output logic              loCpHigh,
  output logic [REF_W-1:0]  hiRefDiv,
  output logic              hiCpHigh,
  output logic [SWAL_W-1:0] loSwallow,
  output logic [PROG_W-1:0] loProgDiv,
  output logic              loPreSel,
  output logic              loPolarity,
  output logic [SWAL_W-1:0] hiSwallow,
  output logic [PROG_W-1:0] hiProgDiv,
  output logic              hiPreSel,
  output logic              hiPolarity,
  output logic [1:0]        testSel,
  output logic              monSelFreq,
  output logic              monOut
);
  strobe_t           strb;
  logic [WORD_W-1:0] shiftWord;
  logic [REF_W-1:0]  refDiv  [2];
  logic              cpHigh  [2];
  logic [SWAL_W-1:0] swallow [2];
  logic [PROG_W-1:0] progDiv [2];
  logic              preSel  [2];
  logic              polarity[2];

  synth_prog_ctrl #(.SYNC_DEPTH(SYNC_DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .serLoad(serLoad), .strb(strb)
  );

  synth_prog_dp dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .lockIn(lockIn),
    .frLo(frLo), .frHi(frHi), .fpLo(fpLo), .fpHi(fpHi),
    .shiftWord(shiftWord), .refDiv(refDiv), .cpHigh(cpHigh),
    .swallow(swallow), .progDiv(progDiv), .preSel(preSel),
    .polarity(polarity), .testSel(testSel), .monSelFreq(monSelFreq),
    .monOut(monOut)
  );

  assign loRefDiv   = refDiv[0];
  assign loCpHigh   = cpHigh[0];
  assign hiRefDiv   = refDiv[1];
  assign hiCpHigh   = cpHigh[1];
  assign loSwallow  = swallow[0];
  assign loProgDiv  = progDiv[0];
  assign loPreSel   = preSel[0];
  assign loPolarity = polarity[0];
  assign hiSwallow  = swallow[1];
  assign hiProgDiv  = progDiv[1];
  assign hiPreSel   = preSel[1];
  assign hiPolarity = polarity[1];
endmodule

// File: rtl/synth_prog_chk.sv
module synth_prog_chk
  import synth_prog_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input strobe_t           strb,
  input logic [WORD_W-1:0] shiftWord,
  input logic [REF_W-1:0]  loRefDiv,
  input logic              loCpHigh,
  input logic [REF_W-1:0]  hiRefDiv,
  input logic              hiCpHigh,
  input logic [SWAL_W-1:0] loSwallow,
  input logic [PROG_W-1:0] loProgDiv,
  input logic [SWAL_W-1:0] hiSwallow,
  input logic [PROG_W-1:0] hiProgDiv
);
  logic [REF_W:0]         loRefGrp, hiRefGrp;
  logic [SWAL_W+PROG_W-1:0] loCntGrp, hiCntGrp;
  assign loRefGrp = {loCpHigh, loRefDiv};
  assign hiRefGrp = {hiCpHigh, hiRefDiv};
  assign loCntGrp = {loSwallow, loProgDiv};
  assign hiCntGrp = {hiSwallow, hiProgDiv};

  // R1: reset clears the settings
  a_r1_reset_clear: assert property (@(posedge clk)
    !rstN |=> (loRefGrp == '0 && hiRefGrp == '0 && loCntGrp == '0 && hiCntGrp == '0));

  // R3: nothing moves without a load strobe
  a_r3_hold_without_load: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadEn |=> ($stable(loRefGrp) && $stable(hiRefGrp) &&
                      $stable(loCntGrp) && $stable(hiCntGrp)));

  // R3: a load touches at most one group
  a_r3_single_target: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadEn |=> $onehot0({!$stable(loRefGrp), !$stable(hiRefGrp),
                              !$stable(loCntGrp), !$stable(hiCntGrp)}));

  // R4: low-band reference load takes the ratio field of the word
  a_r4_lo_ref_field: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadEn && shiftWord[1:0] == 2'b00) |=>
      loRefDiv == $past(shiftWord[POS_REF +: REF_W]));
endmodule

bind synth_prog_if synth_prog_chk chk_i (
  .clk(clk), .rstN(rstN), .strb(strb), .shiftWord(shiftWord),
  .loRefDiv(loRefDiv), .loCpHigh(loCpHigh), .hiRefDiv(hiRefDiv),
  .hiCpHigh(hiCpHigh), .loSwallow(loSwallow), .loProgDiv(loProgDiv),
  .hiSwallow(hiSwallow), .hiProgDiv(hiProgDiv)
);

// File: tb/synth_prog_if_tb.sv
`timescale 1ns/1ps
module synth_prog_if_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serClk = 1'b0, serData = 1'b0, serLoad = 1'b0;
  logic lockIn = 1'b0, frLo = 1'b0, frHi = 1'b0, fpLo = 1'b0, fpHi = 1'b0;
  logic [13:0] loRefDiv, hiRefDiv;
  logic        loCpHigh, hiCpHigh;
  logic [6:0]  loSwallow, hiSwallow;
  logic [10:0] loProgDiv, hiProgDiv;
  logic        loPreSel, loPolarity, hiPreSel, hiPolarity;
  logic [1:0]  testSel;
  logic        monSelFreq, monOut;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  synth_prog_if dut_i (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData), .serLoad(serLoad),
    .lockIn(lockIn), .frLo(frLo), .frHi(frHi), .fpLo(fpLo), .fpHi(fpHi),
    .loRefDiv(loRefDiv), .loCpHigh(loCpHigh), .hiRefDiv(hiRefDiv), .hiCpHigh(hiCpHigh),
    .loSwallow(loSwallow), .loProgDiv(loProgDiv), .loPreSel(loPreSel), .loPolarity(loPolarity),
    .hiSwallow(hiSwallow), .hiProgDiv(hiProgDiv), .hiPreSel(hiPreSel), .hiPolarity(hiPolarity),
    .testSel(testSel), .monSelFreq(monSelFreq), .monOut(monOut)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [22:0] refWord(bit hi, bit [1:0] t, bit [13:0] r, bit cs);
    logic [22:0] w = '0;
    w[0] = hi; w[1] = 1'b0; w[2] = t[1]; w[3] = t[0];
    w[17:4] = r; w[18] = cs; w[22:19] = 4'b1010;
    return w;
  endfunction

  function automatic logic [22:0] progWord(bit hi, bit lds, bit sw, bit fc,
                                           bit [6:0] a, bit [10:0] n);
    logic [22:0] w;
    w[0] = hi; w[1] = 1'b1; w[2] = lds; w[3] = sw; w[4] = fc;
    w[11:5] = a; w[22:12] = n;
    return w;
  endfunction

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bit(bit b);
    serData = b; wait_clk(4);
    serClk = 1'b1; wait_clk(4);
    serClk = 1'b0; wait_clk(4);
  endtask

  task automatic pulse_load();
    serLoad = 1'b1; wait_clk(6);
    serLoad = 1'b0; wait_clk(8);
  endtask

  task automatic send_word(logic [22:0] w);
    for (int i = 22; i >= 0; i--) shift_bit(w[i]);
    pulse_load();
  endtask

  task automatic test_reset();
    check("R1 loRefDiv", loRefDiv, 0);
    check("R1 hiRefDiv", hiRefDiv, 0);
    check("R1 counts", {loSwallow, loProgDiv, hiSwallow, hiProgDiv}, 0);
    check("R1 mode bits", {loCpHigh, hiCpHigh, loPreSel, loPolarity, hiPreSel,
                           hiPolarity, testSel, monSelFreq}, 0);
  endtask

  task automatic test_ref_loads();
    send_word(refWord(1'b0, 2'b00, 14'd16383, 1'b1));
    check("R4 lo ref max", loRefDiv, 16383);
    check("R4 lo cs high", loCpHigh, 1);
    check("R3 hi ref untouched", hiRefDiv, 0);
    send_word(refWord(1'b1, 2'b01, 14'd3, 1'b0));
    check("R4 hi ref min", hiRefDiv, 3);
    check("R4 hi cs low", hiCpHigh, 0);
    check("R3 lo ref kept", {loCpHigh, loRefDiv}, {1'b1, 14'd16383});
    check("R7 testSel from last ref", testSel, 2'b01);
  endtask

  task automatic test_prog_loads();
    send_word(progWord(1'b0, 1'b0, 1'b1, 1'b0, 7'd127, 11'd2047));
    check("R5 lo swallow", loSwallow, 127);
    check("R5 lo prog", loProgDiv, 2047);
    check("R5 lo sw/fc", {loPreSel, loPolarity}, 2'b10);
    check("R3 hi counts untouched", {hiSwallow, hiProgDiv}, 0);
    send_word(progWord(1'b1, 1'b1, 1'b0, 1'b1, 7'd0, 11'd1234));
    check("R5 hi swallow", hiSwallow, 0);
    check("R5 hi prog", hiProgDiv, 1234);
    check("R5 hi sw/fc", {hiPreSel, hiPolarity}, 2'b01);
    check("R7 monSel from last prog", monSelFreq, 1);
    check("R3 refs kept", {loRefDiv, hiRefDiv}, {14'd16383, 14'd3});
  endtask

  task automatic test_clock_under_load();
    logic [22:0] w = refWord(1'b0, 2'b01, 14'd200, 1'b0);
    send_word(refWord(1'b0, 2'b01, 14'd100, 1'b1));
    serLoad = 1'b1; wait_clk(6);
    for (int i = 22; i >= 0; i--) shift_bit(w[i]);
    serLoad = 1'b0; wait_clk(8);
    check("R6 load-high clocks ignored (first load)", loRefDiv, 100);
    pulse_load();
    check("R6 word held, ratio", loRefDiv, 100);
    check("R6 word held, cs", loCpHigh, 1);
  endtask

  task automatic test_extra_bits();
    for (int i = 0; i < 5; i++) shift_bit(1'b1);
    send_word(refWord(1'b1, 2'b01, 14'h1555, 1'b1));
    check("R2 surplus leading bits dropped", hiRefDiv, 14'h1555);
    check("R2 cs after surplus bits", hiCpHigh, 1);
  endtask

  task automatic test_monitor();
    send_word(progWord(1'b1, 1'b0, 1'b0, 1'b1, 7'd0, 11'd1234));
    lockIn = 1'b1; wait_clk(2);
    check("R8 lock shown", monOut, 1);
    lockIn = 1'b0; wait_clk(2);
    check("R8 lock low shown", monOut, 0);
    send_word(progWord(1'b0, 1'b1, 1'b1, 1'b0, 7'd127, 11'd2047));
    for (int t = 0; t < 4; t++) begin
      logic [1:0] ts = 2'(t);
      send_word(refWord(ts[1], ts, 14'd16383, 1'b1));
      {frLo, frHi, fpLo, fpHi} = 4'b0000;
      case (ts)
        2'b00: frLo = 1'b1;
        2'b10: frHi = 1'b1;
        2'b01: fpLo = 1'b1;
        default: fpHi = 1'b1;
      endcase
      lockIn = 1'b0; wait_clk(2);
      check("R8 selected source high", monOut, 1);
      {frLo, frHi, fpLo, fpHi} = ~{frLo, frHi, fpLo, fpHi};
      wait_clk(2);
      check("R8 selected source low", monOut, 0);
    end
    {frLo, frHi, fpLo, fpHi} = 4'b0000;
  endtask

  initial begin
    wait_clk(5);
    test_reset();
    rstN = 1'b1;
    wait_clk(3);
    test_reset();
    test_ref_loads();
    test_prog_loads();
    test_clock_under_load();
    test_extra_bits();
    test_monitor();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule